// File: doc/BRIEF.md
# Register Bank Operand Address Translator

This block turns a short register operand into a physical RAM access for a bank of general-purpose registers kept in on-chip RAM. A movable base register holds the byte address where the bank starts. Word register n sits at base + 2n, and the bank grows upward through 16 words. Sixteen byte registers overlay the first eight word registers. Byte operand b names word b>>1. Bit 0 of b picks the high byte when set and the low byte when clear. Byte ordering is little-endian: the low byte sits at the even address and on lane 0.

An operand arrives as a field of 2, 4 or 8 bits, together with a word/byte flag and a read/write flag. One clock later the block presents a RAM request: a byte address, a two-bit lane enable and the write data, with a byte value copied onto both lanes. On reads, the word that the RAM returns during that request cycle is passed through for word operands. For byte operands the selected lane is extracted and zero-extended. Only the base register forms the address. No page or segment selection takes part.

Writes to the base register always store an even value. A write with bit 0 set is rounded down, and an alignment flag reports it until the next base write.

Top module: `cbk_gpr_xlate`

## Requirements
- R1: After reset the base register reads 0, the alignment flag is 0, and no RAM request or miss is presented.
- R2: A word operand n (0..15) accepted in cycle t produces, in cycle t+1, ram_req=1, ram_be=2'b11 and ram_addr = base + 2n. A write request carries the 16-bit write data unchanged.
- R3: A byte operand b (0..15) addresses word b>>1. It produces ram_addr = base + 2*(b>>1) + b[0], and ram_be = 2'b10 when b[0]=1 (high byte) or 2'b01 when b[0]=0 (low byte).
- R4: A byte write enables exactly one lane, leaving the other byte of the word untouched, and puts op_wdata[7:0] on both data lanes (ram_wdata = {b,b}).
- R5: For a byte read, rd_data = {8'h00, selected lane of ram_rdata}. For a word read, rd_data = ram_rdata.
- R6: A base write stores wr_data with bit 0 cleared in the following cycle. The alignment flag becomes wr_data[0] and holds until the next base write.
- R7: Field format (op_fmt): 0 = 2-bit field, using op_field[1:0] with the upper bits ignored; 1 = 4-bit field, using op_field[3:0]; 2 = 8-bit field, naming a register only when op_field[7:4] = 4'hF, with the number in op_field[3:0]. An 8-bit field outside that range, or op_fmt = 3, raises op_miss for one cycle and issues no request.
- R8: An operand accepted in the same cycle as a base write uses the old base value.
- R9: Address arithmetic wraps modulo 2^ADDR_W, so a bank placed near the top of the address space wraps to low addresses.
- R10: Every word request has an even address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cp_wr_en | input | 1 | Write strobe for the bank base register |
| cp_wr_data | input | ADDR_W | New bank base byte address |
| op_valid | input | 1 | Operand present this cycle |
| op_is_byte | input | 1 | 1 = byte register operand, 0 = word |
| op_is_write | input | 1 | 1 = register write, 0 = read |
| op_fmt | input | 2 | Field format: 0 = 2-bit, 1 = 4-bit, 2 = 8-bit, 3 = invalid |
| op_field | input | 8 | Short register field |
| op_wdata | input | 16 | Write data (byte writes use bits 7:0) |
| ram_rdata | input | 16 | Word returned by RAM during the request cycle |
| ram_req | output | 1 | RAM access request |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | ADDR_W | RAM byte address |
| ram_be | output | 2 | Lane enables, bit 0 = low byte |
| ram_wdata | output | 16 | RAM write data |
| rd_data | output | 16 | Register read result |
| op_miss | output | 1 | Field named no bank register |
| cp_value | output | ADDR_W | Current bank base |
| cp_misalign | output | 1 | Last base write had bit 0 set |

## Verification
The bench sweeps every word and byte register number at several bank bases, including one near the top of the address space. A design that forgot to shift the byte index would spread the sixteen byte registers over all sixteen words. One that swapped the high/low choice would enable the wrong lane and return the wrong half on reads. A missing carry wrap would show at the top-of-space base. Odd base writes are used to show rounding and the flag, and a base write in the same cycle as an operand is used to catch a design that takes the new base too early. Each field format is driven with stray upper bits, and the 8-bit format is driven with out-of-range values that must produce a miss and no request.

// File: rtl/cbk_pkg.sv
package cbk_pkg;

    localparam int WORD_W  = 16;
    localparam int BYTE_W  = 8;
    localparam int LANES   = WORD_W / BYTE_W;
    localparam int FIELD_W = 8;
    localparam int NUM_W   = 4;

    typedef enum logic [1:0] {
        FMT_SHORT2 = 2'd0,
        FMT_SHORT4 = 2'd1,
        FMT_SHORT8 = 2'd2,
        FMT_BAD    = 2'd3
    } fld_fmt_e;

    localparam logic [3:0] SHORT8_PREFIX = 4'hF;

endpackage

// File: rtl/cbk_ctx_ptr.sv
module cbk_ctx_ptr #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_data,
    output logic [ADDR_W-1:0] base_q,
    output logic              misalign_q
);

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic              mis;
    } ctx_st_t;

    ctx_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.base = {wr_data[ADDR_W-1:1], 1'b0};
            st_d.mis  = wr_data[0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign base_q     = st_q.base;
    assign misalign_q = st_q.mis;

    AST_BASE_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        base_q[0] == 1'b0); // R6

    AST_FLAG_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (misalign_q == $past(wr_data[0]))); // R6

    AST_BASE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(base_q)); // R6

endmodule

// File: rtl/cbk_opnd_dec.sv
module cbk_opnd_dec
    import cbk_pkg::*;
(
    input  fld_fmt_e           fmt,
    input  logic               is_byte,
    input  logic [FIELD_W-1:0] field,
    output logic               hit,
    output logic [NUM_W-1:0]   word_idx,
    output logic               hi_sel
);

    logic [NUM_W-1:0] num;

    always_comb begin
        num = '0;
        hit = 1'b0;
        unique case (fmt)
            FMT_SHORT2: begin
                num = {2'b00, field[1:0]};
                hit = 1'b1;
            end
            FMT_SHORT4: begin
                num = field[3:0];
                hit = 1'b1;
            end
            FMT_SHORT8: begin
                num = field[3:0];
                hit = (field[7:4] == SHORT8_PREFIX);
            end
            default: begin
                num = '0;
                hit = 1'b0;
            end
        endcase

        if (is_byte) begin
            word_idx = {1'b0, num[NUM_W-1:1]};
            hi_sel   = num[0];
        end else begin
            word_idx = num;
            hi_sel   = 1'b0;
        end
    end

    always_comb begin
        if (is_byte) assert (word_idx[NUM_W-1] == 1'b0); // R3
    end

endmodule

// File: rtl/cbk_lane.sv
module cbk_lane
    import cbk_pkg::*;
(
    input  logic              is_byte,
    input  logic              hi_sel,
    input  logic [WORD_W-1:0] wdata_in,
    output logic [LANES-1:0]  be,
    output logic [WORD_W-1:0] wdata_out,
    input  logic              rsel_byte,
    input  logic              rsel_hi,
    input  logic [WORD_W-1:0] ram_rdata,
    output logic [WORD_W-1:0] rd_data
);

    logic [BYTE_W-1:0] lane_rd [LANES];

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        localparam logic LANE_HI = (l != 0);
        always_comb begin
            be[l] = !is_byte || (hi_sel == LANE_HI);
            wdata_out[l*BYTE_W +: BYTE_W] = is_byte ? wdata_in[BYTE_W-1:0]
                                                    : wdata_in[l*BYTE_W +: BYTE_W];
            lane_rd[l] = ram_rdata[l*BYTE_W +: BYTE_W];
        end
    end

    always_comb begin
        if (rsel_byte) rd_data = {{(WORD_W-BYTE_W){1'b0}}, lane_rd[rsel_hi]};
        else           rd_data = ram_rdata;
    end

endmodule

// File: rtl/cbk_gpr_xlate.sv
module cbk_gpr_xlate
    import cbk_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cp_wr_en,
    input  logic [ADDR_W-1:0] cp_wr_data,
    input  logic              op_valid,
    input  logic              op_is_byte,
    input  logic              op_is_write,
    input  logic [1:0]        op_fmt,
    input  logic [7:0]        op_field,
    input  logic [15:0]       op_wdata,
    input  logic [15:0]       ram_rdata,
    output logic              ram_req,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [1:0]        ram_be,
    output logic [15:0]       ram_wdata,
    output logic [15:0]       rd_data,
    output logic              op_miss,
    output logic [ADDR_W-1:0] cp_value,
    output logic              cp_misalign
);

    localparam int IDX_PAD  = ADDR_W - NUM_W - 1;
    localparam int BANK_LEN = 2 * (1 << NUM_W);

    typedef struct packed {
        logic              req;
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [LANES-1:0]  be;
        logic [WORD_W-1:0] wdata;
        logic              rbyte;
        logic              rhi;
        logic              miss;
    } req_st_t;

    req_st_t st_d, st_q;

    logic [ADDR_W-1:0] base;
    logic              hit;
    logic [NUM_W-1:0]  word_idx;
    logic              hi_sel;
    logic [LANES-1:0]  be_c;
    logic [WORD_W-1:0] wdata_c;
    logic [ADDR_W-1:0] word_addr;

    cbk_ctx_ptr #(.ADDR_W(ADDR_W)) u_ctx (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (cp_wr_en),
        .wr_data    (cp_wr_data),
        .base_q     (base),
        .misalign_q (cp_misalign)
    );

    cbk_opnd_dec u_dec (
        .fmt      (fld_fmt_e'(op_fmt)),
        .is_byte  (op_is_byte),
        .field    (op_field),
        .hit      (hit),
        .word_idx (word_idx),
        .hi_sel   (hi_sel)
    );

    cbk_lane u_lane (
        .is_byte   (op_is_byte),
        .hi_sel    (hi_sel),
        .wdata_in  (op_wdata),
        .be        (be_c),
        .wdata_out (wdata_c),
        .rsel_byte (st_q.rbyte),
        .rsel_hi   (st_q.rhi),
        .ram_rdata (ram_rdata),
        .rd_data   (rd_data)
    );

    assign word_addr = base + {{IDX_PAD{1'b0}}, word_idx, 1'b0};

    always_comb begin
        st_d       = st_q;
        st_d.req   = 1'b0;
        st_d.miss  = 1'b0;
        if (op_valid) begin
            if (hit) begin
                st_d.req   = 1'b1;
                st_d.we    = op_is_write;
                st_d.addr  = word_addr + {{(ADDR_W-1){1'b0}}, hi_sel};
                st_d.be    = be_c;
                st_d.wdata = wdata_c;
                st_d.rbyte = op_is_byte;
                st_d.rhi   = hi_sel;
            end else begin
                st_d.miss  = 1'b1;
                st_d.we    = 1'b0;
            end
        end else begin
            st_d.we = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ram_req   = st_q.req;
    assign ram_we    = st_q.we;
    assign ram_addr  = st_q.addr;
    assign ram_be    = st_q.be;
    assign ram_wdata = st_q.wdata;
    assign op_miss   = st_q.miss;
    assign cp_value  = base;

    AST_WORD_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_req && ram_be == 2'b11) |-> !ram_addr[0]); // R10

    AST_BYTE_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_req && ram_we && ram_wdata[15:8] != ram_wdata[7:0]) |-> (ram_be == 2'b11)); // R4

    AST_BYTE_LANE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && hit && op_is_byte) |=> ($countones(ram_be) == 1)); // R4

    AST_MISS_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        op_miss |-> !ram_req); // R7

    AST_IN_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && hit) |=> ((ram_addr - $past(cp_value)) < ADDR_W'(BANK_LEN))); // R2

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> (!ram_req && !op_miss && !ram_we)); // R1

endmodule

// File: tb/sim_cbk_gpr_xlate.sv
module sim_cbk_gpr_xlate;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cp_wr_en = 1'b0;
    logic [15:0] cp_wr_data = '0;
    logic        op_valid = 1'b0;
    logic        op_is_byte = 1'b0;
    logic        op_is_write = 1'b0;
    logic [1:0]  op_fmt = 2'd1;
    logic [7:0]  op_field = '0;
    logic [15:0] op_wdata = '0;
    logic [15:0] ram_rdata = '0;
    logic        ram_req, ram_we, op_miss, cp_misalign;
    logic [15:0] ram_addr, ram_wdata, rd_data, cp_value;
    logic [1:0]  ram_be;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    cbk_gpr_xlate #(.ADDR_W(16)) u0 (
        .clk(clk), .rst_n(rst_n), .cp_wr_en(cp_wr_en), .cp_wr_data(cp_wr_data),
        .op_valid(op_valid), .op_is_byte(op_is_byte), .op_is_write(op_is_write),
        .op_fmt(op_fmt), .op_field(op_field), .op_wdata(op_wdata),
        .ram_rdata(ram_rdata), .ram_req(ram_req), .ram_we(ram_we),
        .ram_addr(ram_addr), .ram_be(ram_be), .ram_wdata(ram_wdata),
        .rd_data(rd_data), .op_miss(op_miss), .cp_value(cp_value),
        .cp_misalign(cp_misalign)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_base(input logic [15:0] v, input string req);
        @(negedge clk);
        cp_wr_en = 1'b1; cp_wr_data = v;
        @(negedge clk);
        cp_wr_en = 1'b0;
        chk(req, {47'd0, cp_misalign, cp_value}, {47'd0, v[0], v & 16'hFFFE});
    endtask

    // Issues one operand and checks the request; expected values derived from R2..R7.
    task automatic run_op(input logic [1:0] fmt, input logic byt, input logic wr,
                          input logic [7:0] fld, input logic [15:0] wd,
                          input logic [15:0] base, input logic [15:0] rdpat,
                          input string req);
        logic        h;
        logic [3:0]  num;
        logic [15:0] ea, ewd, erd;
        logic [1:0]  ebe;
        h = 1'b1;
        case (fmt)
            2'd0: num = {2'b00, fld[1:0]};
            2'd1: num = fld[3:0];
            2'd2: begin num = fld[3:0]; h = (fld[7:4] == 4'hF); end
            default: begin num = 4'd0; h = 1'b0; end
        endcase
        if (byt) begin
            ea  = base + 16'(2 * (num / 2)) + 16'(num % 2);
            ebe = (num % 2 == 1) ? 2'b10 : 2'b01;
            ewd = {wd[7:0], wd[7:0]};
            erd = (num % 2 == 1) ? {8'h00, rdpat[15:8]} : {8'h00, rdpat[7:0]};
        end else begin
            ea  = base + 16'(2 * num);
            ebe = 2'b11;
            ewd = wd;
            erd = rdpat;
        end
        @(negedge clk);
        op_valid = 1'b1; op_fmt = fmt; op_is_byte = byt; op_is_write = wr;
        op_field = fld; op_wdata = wd;
        @(negedge clk);
        op_valid = 1'b0;
        ram_rdata = rdpat;
        #1;
        if (!h) begin
            chk(req, {61'd0, op_miss, ram_req, ram_we}, {61'd0, 3'b100});
        end else if (wr) begin
            chk(req, {13'd0, op_miss, ram_req, ram_we, ram_addr, ram_be, ram_wdata},
                     {13'd0, 1'b0, 1'b1, 1'b1, ea, ebe, ewd});
        end else begin
            chk(req, {13'd0, op_miss, ram_req, ram_we, ram_addr, ram_be, rd_data},
                     {13'd0, 1'b0, 1'b1, 1'b0, ea, ebe, erd});
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        logic [15:0] bases [4];
        bases[0] = 16'h0000; bases[1] = 16'hFC00; bases[2] = 16'h3A7E; bases[3] = 16'hFFF0;

        repeat (3) @(negedge clk);
        chk("R1 reset", {44'd0, ram_req, op_miss, cp_misalign, cp_value},
                        {44'd0, 3'b000, 16'h0000});
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset", {61'd0, ram_req, op_miss, cp_misalign}, 64'd0);

        for (int b = 0; b < 4; b++) begin
            set_base(bases[b], "R6 even base");
            for (int n = 0; n < 16; n++) begin
                run_op(2'd1, 1'b0, 1'b1, 8'(n), 16'(16'hA500 + n * 16'h0111), bases[b], 16'h0, "R2 R9 word write");
                run_op(2'd1, 1'b0, 1'b0, 8'(n), 16'h0, bases[b], 16'(16'h1357 * (n + 1)), "R2 word read");
                run_op(2'd1, 1'b1, 1'b1, 8'(n), 16'(16'hEE00 + 16'(n * 7)), bases[b], 16'h0, "R3 R4 byte write");
                run_op(2'd1, 1'b1, 1'b0, 8'(n), 16'h0, bases[b], 16'(16'hC3A5 ^ (n * 16'h1111)), "R3 R5 byte read");
            end
        end

        set_base(16'h2345, "R6 odd base rounded");
        run_op(2'd1, 1'b0, 1'b0, 8'd15, 16'h0, 16'h2344, 16'hBEEF, "R6 R10 odd base word");
        run_op(2'd1, 1'b1, 1'b1, 8'd7, 16'h5AC3, 16'h2344, 16'h0, "R6 byte after odd base");
        set_base(16'h0400, "R6 flag cleared");

        for (int n = 0; n < 4; n++) begin
            run_op(2'd0, 1'b0, 1'b1, {6'b101101, 2'(n)}, 16'h1234, 16'h0400, 16'h0, "R7 short2 word");
            run_op(2'd0, 1'b1, 1'b0, {6'b110011, 2'(n)}, 16'h0, 16'h0400, 16'h9A6B, "R7 short2 byte");
        end
        run_op(2'd1, 1'b0, 1'b1, 8'hD9, 16'h4321, 16'h0400, 16'h0, "R7 short4 upper ignored");
        for (int n = 0; n < 16; n++) begin
            run_op(2'd2, 1'b0, 1'b0, {4'hF, 4'(n)}, 16'h0, 16'h0400, 16'(16'h0F0F + n), "R7 short8 hit");
            run_op(2'd2, 1'b1, 1'b1, {4'(n), 4'(n)}, 16'h77AA, 16'h0400, 16'h0, "R7 short8 range");
        end
        run_op(2'd3, 1'b0, 1'b1, 8'h03, 16'hFFFF, 16'h0400, 16'h0, "R7 bad format miss");

        // R8: operand in same cycle as base write uses old base
        @(negedge clk);
        cp_wr_en = 1'b1; cp_wr_data = 16'h8000;
        op_valid = 1'b1; op_fmt = 2'd1; op_is_byte = 1'b0; op_is_write = 1'b1;
        op_field = 8'd5; op_wdata = 16'h6060;
        @(negedge clk);
        cp_wr_en = 1'b0; op_valid = 1'b0;
        chk("R8 old base used", {32'd0, ram_addr, cp_value}, {32'd0, 16'h040A, 16'h8000});
        run_op(2'd1, 1'b0, 1'b1, 8'd5, 16'h6060, 16'h8000, 16'h0, "R8 new base next op");

        @(negedge clk);
        chk("R1 idle no request", {62'd0, ram_req, op_miss}, 64'd0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule